// File: doc/BRIEF.md
# Transmit Dominant Guard

This block sits in a CAN transceiver's digital core, between the serial transmit-data input that comes from the protocol controller and the enable of the analog bus driver. It passes a low on transmit data through as a dominant command. It also keeps a faulty node from holding the bus dominant without end. The transmit input is synchronized first. A falling edge arms a low-time counter. If the input stays low beyond a set number of clock cycles, the driver is forced recessive and stays that way until a rising edge arrives.

A thermal-shutdown flag switches the driver off. The off-state is held until the flag has cleared and transmit data has returned high, so a node never resumes in the middle of a dominant bit. An I/O-supply undervoltage flag and a mode input that is not "normal" each force the driver recessive directly, with no clock delay. Two status bits report which guard, timeout or thermal, is holding the driver off.

Top module: `tx_dom_guard`

## Requirements
- R1: Out of reset, drive_dom_o is 0 and status_o is 2'b00. The transmit synchronizer resets to high, so an input that has not yet been driven low counts as recessive.
- R2: With mode_normal_i=1, vio_uv_i=0 and no fault held, drive_dom_o follows the inverse of txd_i. The delay is SYNC_STAGES clock edges, and a low requests dominant.
- R3: Once synchronized transmit data has been low for TIMEOUT_CYC clock edges after its falling edge, drive_dom_o goes to 0 and status_o[0] goes to 1.
- R4: The timeout state is held for as long as transmit data stays low. It clears one cycle after the synchronized rising edge. The next low period then gets a fresh full window of TIMEOUT_CYC cycles.
- R5: When the synchronized thermal flag is 1, drive_dom_o is 0 and status_o[1] is 1.
- R6: After the thermal flag clears, the thermal off-state stays in force while transmit data is low. It ends at the first clock edge at which the synchronized thermal flag is 0 and synchronized transmit data is 1.
- R7: vio_uv_i=1 forces drive_dom_o to 0 in the same cycle. It has no effect on the timeout counter or the thermal state, so dominant resumes as soon as the flag drops if no guard has tripped.
- R8: mode_normal_i=0 forces drive_dom_o to 0 in the same cycle.
- R9: status_o bit 0 reports a timeout and bit 1 reports a thermal off-state. Both bits can be 1 at once.
- R10: A low period shorter than TIMEOUT_CYC cycles leaves no timeout state behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| txd_i | input | 1 | Transmit data from the protocol controller, low = dominant |
| therm_i | input | 1 | Over-temperature flag from the sensor |
| vio_uv_i | input | 1 | I/O-supply undervoltage flag |
| mode_normal_i | input | 1 | 1 when the mode controller selects normal operation |
| drive_dom_o | output | 1 | Dominant command to the bus driver |
| status_o | output | 2 | {thermal off, timeout off} |

## Verification
Short low pulses, shorter than the timeout window, show that plain bit traffic passes with the synchronizer delay and leaves no state behind. A long low held past the window shows the exact trip cycle. The bench then releases and re-lowers transmit data to tell clearing by an edge from clearing by time. For the thermal guard, the flag is dropped while transmit data is still low, which tells the two-condition release apart from a release on the flag alone. Undervoltage and mode pulses placed in the middle of a low period show that these gates are combinational and leave the timer untouched. A run in which both guards trip shows the two status bits together.

// File: rtl/tdg_pkg.sv
package tdg_pkg;
  typedef struct packed {
    logic thermal;
    logic timeout;
  } tdg_status_t;
endpackage

// File: rtl/tdg_sync.sv
module tdg_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= RST_VAL;
        else         chain_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/tdg_timeout.sv
module tdg_timeout #(
  parameter int TIMEOUT_CYC = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic txd_s_i,
  output logic timeout_o
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC);

  logic          txd_q;
  logic          armed_q;
  logic [CW-1:0] cnt_q;
  logic          fall, rise;

  assign fall = txd_q & ~txd_s_i;
  assign rise = ~txd_q & txd_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txd_q   <= 1'b1;
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      txd_q <= txd_s_i;
      if (rise) begin
        armed_q <= 1'b0;
        cnt_q   <= '0;
      end else if (fall) begin
        armed_q <= 1'b1;
        cnt_q   <= CW'(1);
      end else if (armed_q && cnt_q != LIMIT) begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assign timeout_o = armed_q && (cnt_q == LIMIT);

  a_r4_hold_while_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_o && !txd_s_i) |=> timeout_o);
  a_r3_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIMIT);
  a_r10_no_trip_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txd_s_i && $past(txd_s_i)) |-> !timeout_o);
endmodule

// File: rtl/tdg_thermal.sv
module tdg_thermal (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic therm_s_i,
  input  logic txd_s_i,
  output logic off_o
);
  logic latch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        latch_q <= 1'b0;
    else if (therm_s_i) latch_q <= 1'b1;
    else if (txd_s_i)   latch_q <= 1'b0;
  end

  assign off_o = therm_s_i | latch_q;

  a_r5_latch_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    therm_s_i |=> latch_q);
  a_r6_release_cond: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(latch_q) |-> ($past(txd_s_i) && !$past(therm_s_i)));
endmodule

// File: rtl/tx_dom_guard.sv
module tx_dom_guard
  import tdg_pkg::*;
#(
  parameter int TIMEOUT_CYC = 100000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       txd_i,
  input  logic       therm_i,
  input  logic       vio_uv_i,
  input  logic       mode_normal_i,
  output logic       drive_dom_o,
  output logic [1:0] status_o
);
  logic        txd_s, therm_s, timeout, th_off;
  tdg_status_t st;

  tdg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_txd (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(txd_i), .q_o(txd_s));

  tdg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_therm (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(therm_i), .q_o(therm_s));

  tdg_timeout #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timeout (
    .clk_i(clk_i), .rst_ni(rst_ni), .txd_s_i(txd_s), .timeout_o(timeout));

  tdg_thermal u_thermal (
    .clk_i(clk_i), .rst_ni(rst_ni), .therm_s_i(therm_s), .txd_s_i(txd_s),
    .off_o(th_off));

  assign drive_dom_o = mode_normal_i & ~vio_uv_i & ~txd_s & ~timeout & ~th_off;

  always_comb begin
    st.timeout = timeout;
    st.thermal = th_off;
  end
  assign status_o = st;

  a_r2_dom_needs_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_dom_o |-> !txd_s);
  a_r7_uv_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vio_uv_i |-> !drive_dom_o);
  a_r8_mode_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_normal_i |-> !drive_dom_o);
  a_r9_status_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o != 2'b00) |-> !drive_dom_o);
endmodule

// File: tb/tx_dom_guard_tb.sv
module tx_dom_guard_tb;
  localparam int LIM = 20;
  localparam int SS  = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic txd = 1'b1, therm = 1'b0, uv = 1'b0, mode = 1'b1;
  logic drive;
  logic [1:0] status;

  int n_checks = 0, n_fail = 0;
  string phase = "R1";
  bit done = 0;

  always #10 clk = ~clk;

  tx_dom_guard #(.TIMEOUT_CYC(LIM), .SYNC_STAGES(SS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .txd_i(txd), .therm_i(therm),
    .vio_uv_i(uv), .mode_normal_i(mode), .drive_dom_o(drive), .status_o(status));

  // behavioural model: delay queues plus a low-run length and a sticky thermal flag
  int tq[$], hq[$];
  int low_run, th_hold;

  function automatic int exp_timeout();
    return (low_run >= LIM) ? 1 : 0;
  endfunction
  function automatic int exp_thermal();
    return (hq[0] != 0 || th_hold != 0) ? 1 : 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tq = {}; hq = {};
      for (int i = 0; i < SS; i++) begin tq.push_back(1); hq.push_back(0); end
      low_run = 0; th_hold = 0;
    end else begin
      if (tq[0] == 0) begin if (low_run < LIM) low_run++; end
      else low_run = 0;
      if (hq[0] != 0) th_hold = 1;
      else if (tq[0] != 0) th_hold = 0;
      void'(tq.pop_front()); tq.push_back(int'(txd));
      void'(hq.pop_front()); hq.push_back(int'(therm));
      #5;
      compare();
    end
  end

  task automatic compare();
    int ed, es;
    es = exp_thermal() * 2 + exp_timeout();
    ed = (mode && !uv && tq[0] == 0 && es == 0) ? 1 : 0;
    n_checks++;
    if (int'(drive) != ed || int'(status) != es) begin
      n_fail++;
      $display("FAIL %s drive=%0d status=%0d expected drive=%0d status=%0d at %0t",
               phase, drive, status, ed, es, $time);
    end
  endtask

  task automatic chk(string req, logic d, logic [1:0] s);
    n_checks++;
    if (drive !== d || status !== s) begin
      n_fail++;
      $display("FAIL %s drive=%0d status=%0d expected drive=%0d status=%0d",
               req, drive, status, d, s);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        wait_cyc(3);
        chk("R1", 1'b0, 2'b00);
        rst_n = 1'b1;
        wait_cyc(3);
        chk("R1", 1'b0, 2'b00);
        // R2 / R10: short lows pass through and leave no timeout
        phase = "R2";
        for (int k = 0; k < 4; k++) begin
          txd = 0; wait_cyc(5 + k);
          txd = 1; wait_cyc(4);
        end
        phase = "R10";
        txd = 0; wait_cyc(LIM - 2); txd = 1; wait_cyc(4);
        chk("R10", 1'b0, 2'b00);
        // R3: stuck low trips; R4: holds until a rising edge
        phase = "R3";
        txd = 0; wait_cyc(LIM + 10);
        chk("R3", 1'b0, 2'b01);
        phase = "R4";
        wait_cyc(10);
        txd = 1; wait_cyc(5);
        chk("R4", 1'b0, 2'b00);
        txd = 0; wait_cyc(SS + 2);
        chk("R4", 1'b1, 2'b00);
        txd = 1; wait_cyc(5);
        // R5 / R6: thermal trip while low, flag cleared while still low
        phase = "R5";
        txd = 0; wait_cyc(4);
        therm = 1; wait_cyc(4);
        chk("R5", 1'b0, 2'b10);
        phase = "R6";
        therm = 0; wait_cyc(6);
        chk("R6", 1'b0, 2'b10);
        txd = 1; wait_cyc(5);
        chk("R6", 1'b0, 2'b00);
        txd = 0; wait_cyc(4);
        chk("R6", 1'b1, 2'b00);
        txd = 1; wait_cyc(4);
        // R7: undervoltage gates at once, timer untouched
        phase = "R7";
        txd = 0; wait_cyc(4);
        uv = 1; #1; chk("R7", 1'b0, 2'b00); wait_cyc(3);
        uv = 0; #1; chk("R7", 1'b1, 2'b00); wait_cyc(LIM);
        chk("R7", 1'b0, 2'b01);
        txd = 1; wait_cyc(5);
        // R8: mode gate
        phase = "R8";
        txd = 0; wait_cyc(4);
        mode = 0; #1; chk("R8", 1'b0, 2'b00); wait_cyc(3);
        mode = 1; #1; chk("R8", 1'b1, 2'b00);
        txd = 1; wait_cyc(5);
        // R9: both guards at once
        phase = "R9";
        txd = 0; wait_cyc(LIM + 4);
        therm = 1; wait_cyc(4);
        chk("R9", 1'b0, 2'b11);
        therm = 0; wait_cyc(4);
        txd = 1; wait_cyc(5);
        chk("R9", 1'b0, 2'b00);
        done = 1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          n_checks++; n_fail++;
          $display("FAIL watchdog: run did not finish, expected completion");
        end
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule